// File: doc/BRIEF.md
# Serial register slave with selectable wiring and bit order

This block is a serial-port slave that gives a host access to a bank of 8-bit control registers. The host lowers an active-low enable, sends a 16-bit instruction, and then moves one to eight data bytes in the same enable window. The instruction carries three things: whether the bytes are written or read, how many bytes follow, and the register address of the first byte. Each following byte moves to the neighbouring address. The address counts down when bits travel most-significant first and counts up when they travel least-significant first.

Register 0 controls the port. It is laid out as mirrored bit pairs that are ORed together, so the host can write it correctly whichever bit order is active. One pair chooses the bit order. One pair chooses between a 4-wire bus and a 3-wire bus; on the 3-wire bus, read data comes back on the shared line through a separate output enable. One pair holds every other register at its default value and blocks writes to those registers. A new bit order or wiring mode only takes effect when enable rises at a frame boundary.

The serial pins are synchronised into the system clock. The bank contents are presented continuously as a flat vector for the surrounding chip to use. That vector is a plain level and has no handshake. The serial side cannot be stalled, so the block applies no back-pressure anywhere.

Top module: `spi_regslave`

## Requirements
- R1: An instruction is 16 bits. Bit 15 = 1 means write and 0 means read. Bits 14:12 hold N, and N+1 data bytes follow. Bits 11:10 have no effect. Bits 9:0 hold the first address.
- R2: Input bits are sampled on the falling serial-clock edge, and read bits are driven after the rising edge. The first read bit is driven on the rising edge that follows the last instruction bit. A written byte appears on `regs_o` no later than 4 clk cycles after its last falling edge.
- R3: With bit-order pair clear, which is the default, every field travels most-significant bit first, and the address decrements by one after each byte.
- R4: With bit-order pair set, every field travels least-significant bit first, and the address increments by one after each byte.
- R5: Register 0 pairs its bits as 7 with 0, 6 with 1, and 5 with 2. A written 1 in either bit of a pair stores 1 in both. Bits 4 and 3 always read 0. Pair 5/2 selects bit order, pair 6/1 selects 3-wire mode, and pair 7/0 is the soft reset.
- R6: In 3-wire mode, read bits appear on `spi_sdio_out` with `spi_sdio_oe` high, `spi_sdo_oe` stays low, and instruction and write bits are taken from `spi_sdi`.
- R7: In 4-wire mode, which is the default, read bits appear on `spi_sdo` with `spi_sdo_oe` high, and `spi_sdio_oe` stays low.
- R8: While `spi_csn` is high, both output enables are low and clock and data edges are ignored. A frame interrupted this way continues from the same bit when enable returns low.
- R9: While the soft-reset pair is set, registers 1 to NUM_REGS-1 hold their defaults and writes to them are dropped. Register 0 stays writable, so the pair can be cleared.
- R10: A change of bit order or wiring mode written to register 0 takes effect only when `spi_csn` rises while no frame is partly transferred.
- R11: Writes to addresses at or above NUM_REGS are dropped, and reads from those addresses return 0x00.
- R12: After `rst_n` is released, register 0 reads 0x00 and register i (i ≥ 1) reads (29·i + 3) mod 256.
- R13: With `spi_csn` held low, a new instruction starts on the bit right after the last data bit of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low transfer enable |
| spi_sdi | input | 1 | Serial data in (the shared line in 3-wire mode) |
| spi_sdo | output | 1 | Serial read data, 4-wire mode |
| spi_sdo_oe | output | 1 | Drive enable for `spi_sdo` |
| spi_sdio_out | output | 1 | Read data for the shared line, 3-wire mode |
| spi_sdio_oe | output | 1 | Drive enable for the shared line |
| regs_o | output | NUM_REGS*8 | Register bank, register i at bits 8i+7:8i |

## Verification
The serial pins pass through two synchroniser stages and one edge-detect flop. As a result, a read bit appears on the data line 3 clk cycles after the rising serial edge. A written byte reaches `regs_o` 4 cycles after its final falling edge, and a new mode is in force 3 cycles after enable rises. The bench holds each serial-clock level for 8 cycles. It captures read bits at the falling serial edge, against expected bytes queued when the frame was issued, and checks the register bank only after enable has been high for 8 cycles. Every result is therefore due at least 4 cycles before it is sampled. The output enables are gated directly by the raw enable pin, so the check that they drop during a suspension is made the cycle after enable rises.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;

  localparam int INSTR_BITS = 16;
  localparam int BYTE_BITS  = 8;
  localparam int ADDR_W     = 10;

  // register 0 bit positions; the pairing is part of the behaviour
  localparam int CFG_SRST_HI = 7;
  localparam int CFG_3W_HI   = 6;
  localparam int CFG_LSB_HI  = 5;
  localparam int CFG_LSB_LO  = 2;
  localparam int CFG_3W_LO   = 1;
  localparam int CFG_SRST_LO = 0;

  typedef enum logic {
    PH_INSTR = 1'b0,
    PH_DATA  = 1'b1
  } spi_phase_e;

  // fold a written value onto its mirror image; the middle bits hold nothing
  function automatic logic [7:0] cfg_fold(input logic [7:0] w);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = w[i] | w[7-i];
    r[4] = 1'b0;
    r[3] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] reg_default(input int idx);
    return 8'((idx * 29 + 3) % 256);
  endfunction

endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
  parameter int              STAGES  = 2,
  parameter int              WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_rs_engine.sv
module spi_rs_engine
  import spi_rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi,
  input  logic              lsb_first,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              at_boundary,
  output logic              rd_phase,
  output logic              dout
);

  localparam logic [3:0] LAST_INSTR = 4'(INSTR_BITS - 1);
  localparam logic [3:0] LAST_DATA  = 4'(BYTE_BITS - 1);

  spi_phase_e        phase_q;
  logic [3:0]        cnt_q;
  logic [15:0]       instr_q;
  logic [7:0]        rx_q;
  logic [7:0]        tx_q;
  logic [2:0]        left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              is_wr_q;
  logic              dout_q;
  logic              wr_valid_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;

  logic [15:0]       instr_nx;
  logic [7:0]        rx_nx;
  logic [ADDR_W-1:0] addr_step;
  logic [2:0]        tx_sel;

  always_comb begin
    instr_nx  = lsb_first ? {sdi, instr_q[15:1]} : {instr_q[14:0], sdi};
    rx_nx     = lsb_first ? {sdi, rx_q[7:1]}     : {rx_q[6:0], sdi};
    addr_step = lsb_first ? addr_q + ADDR_W'(1)  : addr_q - ADDR_W'(1);
    rd_addr   = (phase_q == PH_INSTR) ? instr_nx[ADDR_W-1:0] : addr_step;
    tx_sel    = lsb_first ? cnt_q[2:0] : 3'd7 - cnt_q[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_INSTR;
      cnt_q      <= '0;
      instr_q    <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      left_q     <= '0;
      addr_q     <= '0;
      is_wr_q    <= 1'b0;
      dout_q     <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      wr_valid_q <= 1'b0;
      if (active && sclk_fall) begin
        if (phase_q == PH_INSTR) begin
          instr_q <= instr_nx;
          if (cnt_q == LAST_INSTR) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            is_wr_q <= instr_nx[15];
            left_q  <= instr_nx[14:12];
            addr_q  <= instr_nx[ADDR_W-1:0];
            tx_q    <= rd_data;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end else begin
          rx_q <= rx_nx;
          if (cnt_q == LAST_DATA) begin
            cnt_q <= '0;
            if (is_wr_q) begin
              wr_valid_q <= 1'b1;
              wr_addr_q  <= addr_q;
              wr_data_q  <= rx_nx;
            end
            if (left_q == 3'd0) begin
              phase_q <= PH_INSTR;
            end else begin
              left_q <= left_q - 3'd1;
              addr_q <= addr_step;
              tx_q   <= rd_data;
            end
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
      end
      if (active && sclk_rise && phase_q == PH_DATA && !is_wr_q) begin
        dout_q <= tx_q[tx_sel];
      end
    end
  end

  assign wr_valid    = wr_valid_q;
  assign wr_addr     = wr_addr_q;
  assign wr_data     = wr_data_q;
  assign at_boundary = (phase_q == PH_INSTR) && (cnt_q == 4'd0);
  assign rd_phase    = (phase_q == PH_DATA) && !is_wr_q;
  assign dout        = dout_q;

endmodule

// File: rtl/spi_rs_bank.sv
module spi_rs_bank
  import spi_rs_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  input  logic                  cfg_apply,
  output logic                  act_lsb,
  output logic                  act_3w,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  logic [7:0] cfg_q;
  logic       soft_q;
  logic       act_lsb_q;
  logic       act_3w_q;

  assign soft_q = cfg_q[CFG_SRST_HI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      act_lsb_q <= 1'b0;
      act_3w_q  <= 1'b0;
    end else begin
      if (wr_valid && wr_addr == '0) cfg_q <= cfg_fold(wr_data);
      if (cfg_apply) begin
        act_lsb_q <= cfg_q[CFG_LSB_LO];
        act_3w_q  <= cfg_q[CFG_3W_LO];
      end
    end
  end

  assign regs_flat[7:0] = cfg_q;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   r_q <= reg_default(g);
      else if (soft_q)                              r_q <= reg_default(g);
      else if (wr_valid && wr_addr == ADDR_W'(g))   r_q <= wr_data;
    end
    assign regs_flat[8*g +: 8] = r_q;
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NUM_REGS) rd_data = regs_flat[int'(rd_addr)*8 +: 8];
  end

  assign act_lsb = act_lsb_q;
  assign act_3w  = act_3w_q;

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_rs_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sclk,
  input  logic                  spi_csn,
  input  logic                  spi_sdi,
  output logic                  spi_sdo,
  output logic                  spi_sdo_oe,
  output logic                  spi_sdio_out,
  output logic                  spi_sdio_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic [2:0]        pins_s;
  logic              sclk_s, csn_s, sdi_s;
  logic              sclk_d, csn_d;
  logic              sclk_rise, sclk_fall, csn_rise;
  logic              cfg_apply;
  logic              act_lsb, act_3w;
  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;
  logic              at_boundary, rd_phase, dout;
  logic              drive_rd;

  spi_rs_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_sclk, spi_csn, spi_sdi}),
    .q    (pins_s)
  );

  assign {sclk_s, csn_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign csn_rise  = csn_s & ~csn_d;
  assign cfg_apply = csn_rise & at_boundary;

  spi_rs_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (~csn_s),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .sdi        (sdi_s),
    .lsb_first  (act_lsb),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .at_boundary(at_boundary),
    .rd_phase   (rd_phase),
    .dout       (dout)
  );

  spi_rs_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cfg_apply(cfg_apply),
    .act_lsb  (act_lsb),
    .act_3w   (act_3w),
    .regs_flat(regs_o)
  );

  assign drive_rd     = ~spi_csn & rd_phase;
  assign spi_sdo      = dout;
  assign spi_sdio_out = dout;
  assign spi_sdo_oe   = drive_rd & ~act_3w;
  assign spi_sdio_oe  = drive_rd & act_3w;

endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk #(
  parameter int NUM_REGS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  csn,
  input logic                  sdo_oe,
  input logic                  sdio_oe,
  input logic                  wr_valid,
  input logic                  cfg_apply,
  input logic                  act_lsb,
  input logic                  act_3w,
  input logic [NUM_REGS*8-1:0] regs
);

  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> (!sdo_oe && !sdio_oe));

  a_r6_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));

  a_r5_cfg_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[7] == regs[0]) && (regs[6] == regs[1]) && (regs[5] == regs[2]) && (regs[4:3] == 2'b00));

  a_r10_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lsb != $past(act_lsb) || act_3w != $past(act_3w)) |-> $past(cfg_apply));

  a_r9_defaults_held: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[0] && $past(regs[0]) && $past(regs[0], 2)) |-> $stable(regs[NUM_REGS*8-1:8]));

  a_r2_write_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

endmodule

bind spi_regslave spi_regslave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn      (spi_csn),
  .sdo_oe   (spi_sdo_oe),
  .sdio_oe  (spi_sdio_oe),
  .wr_valid (wr_valid),
  .cfg_apply(cfg_apply),
  .act_lsb  (act_lsb),
  .act_3w   (act_3w),
  .regs     (regs_o)
);

// File: tb/test_spi_regslave.sv
`timescale 1ns/1ps
module test_spi_regslave;

  localparam int NREG = 16;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csn = 1'b1;
  logic mosi = 1'b0;
  logic dut_sdi;
  logic sdo, sdo_oe, sdio_out, sdio_oe;
  logic [NREG*8-1:0] regs;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] exp_q [$];
  bit tb_lsb = 1'b0;
  bit tb_3w = 1'b0;
  string cur_req = "R2";

  always #10 clk = ~clk;

  assign dut_sdi = sdio_oe ? sdio_out : mosi;

  spi_regslave #(.NUM_REGS(NREG)) i_spi_regslave (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk    (sclk),
    .spi_csn     (csn),
    .spi_sdi     (dut_sdi),
    .spi_sdo     (sdo),
    .spi_sdo_oe  (sdo_oe),
    .spi_sdio_out(sdio_out),
    .spi_sdio_oe (sdio_oe),
    .regs_o      (regs)
  );

  function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endfunction

  function automatic logic [7:0] dflt(int r);
    return 8'((r * 29 + 3) % 256);
  endfunction

  function automatic void mdl_write(logic [9:0] a, logic [7:0] d);
    if (a == 10'd0) begin
      mdl[0] = {d[7] | d[0], d[6] | d[1], d[5] | d[2], 2'b00, d[2] | d[5], d[1] | d[6], d[0] | d[7]};
      if (mdl[0][7]) for (int r = 1; r < NREG; r++) mdl[r] = dflt(r);
    end else if (int'(a) < NREG && !mdl[0][7]) begin
      mdl[a] = d;
    end
  endfunction

  function automatic logic [7:0] mdl_read(logic [9:0] a);
    return (int'(a) < NREG) ? mdl[a] : 8'h00;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(logic b);
    @(negedge clk);
    sclk = 1'b1;
    mosi = b;
    wait_clk(HALF);
    sclk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic chk_all(string req);
    for (int r = 0; r < NREG; r++) chk(req, regs[8*r +: 8], mdl[r]);
  endtask

  task automatic suspend();
    csn = 1'b1;
    wait_clk(1);
    chk("R8", {sdo_oe, sdio_oe}, 2'b00);
    wait_clk(5);
    for (int t = 0; t < 3; t++) begin
      sclk = 1'b1; mosi = ~mosi; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    chk("R8", {sdo_oe, sdio_oe}, 2'b00);
    csn = 1'b0;
    wait_clk(4);
  endtask

  task automatic end_frame();
    wait_clk(4);
    csn = 1'b1;
    wait_clk(8);
    tb_lsb = mdl[0][2];
    tb_3w  = mdl[0][1];
  endtask

  // driver: queues the bytes a read must return, then clocks the frame
  task automatic spi_frame(string req, bit wr, int nbytes, logic [9:0] addr, logic [1:0] dc,
                           logic [63:0] wdata, int susp_at, bit keep_low);
    logic [15:0] ins;
    logic [9:0]  a;
    logic [7:0]  bv;
    logic        b;
    int          total;
    cur_req = req;
    ins = {wr, 3'(nbytes - 1), dc, addr};
    if (!wr) begin
      a = addr;
      for (int k = 0; k < nbytes; k++) begin
        exp_q.push_back(mdl_read(a));
        a = tb_lsb ? a + 10'd1 : a - 10'd1;
      end
    end
    if (csn) begin csn = 1'b0; wait_clk(4); end
    total = 16 + 8 * nbytes;
    for (int i = 0; i < total; i++) begin
      if (i == susp_at) suspend();
      if (i < 16) begin
        b = tb_lsb ? ins[i] : ins[15-i];
      end else begin
        bv = wdata[8*((i-16)/8) +: 8];
        b  = wr ? (tb_lsb ? bv[(i-16)%8] : bv[7-((i-16)%8)]) : 1'b0;
      end
      spi_bit(b);
    end
    if (wr) begin
      a = addr;
      for (int k = 0; k < nbytes; k++) begin
        mdl_write(a, wdata[8*k +: 8]);
        a = tb_lsb ? a + 10'd1 : a - 10'd1;
      end
    end
    if (!keep_low) begin
      end_frame();
      chk_all(req);
    end
  endtask

  // monitor: assembles returned bytes at the host sampling edge and scores them
  initial begin
    logic [7:0] acc;
    int nb;
    logic bitv;
    acc = '0;
    nb = 0;
    forever begin
      @(negedge sclk);
      if (!csn && (sdo_oe || sdio_oe)) begin
        bitv = sdio_oe ? sdio_out : sdo;
        acc  = tb_lsb ? {bitv, acc[7:1]} : {acc[6:0], bitv};
        nb++;
        if (nb == 8) begin
          nb = 0;
          chk(tb_3w ? "R6" : "R7", {sdo_oe, sdio_oe}, tb_3w ? 2'b01 : 2'b10);
          if (exp_q.size() == 0) chk("R2 unexpected read byte", 1, 0);
          else chk(cur_req, acc, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    wait_clk(150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mdl[0] = 8'h00;
    for (int r = 1; r < NREG; r++) mdl[r] = dflt(r);
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    chk_all("R12");
    chk("R7", {sdo_oe, sdio_oe}, 2'b00);

    // R1: single write, then multibyte write with don't-care bits set
    spi_frame("R1", 1'b1, 1, 10'd3, 2'b00, 64'hA5, -1, 1'b0);
    spi_frame("R3", 1'b1, 3, 10'd9, 2'b11, 64'h33_22_11, -1, 1'b0);
    // R3: read across four descending addresses, first bit right after the instruction
    spi_frame("R3", 1'b0, 4, 10'd9, 2'b10, 64'h0, -1, 1'b0);
    // R11: addresses past the bank
    spi_frame("R11", 1'b1, 1, 10'h200, 2'b00, 64'h5A, -1, 1'b0);
    spi_frame("R11", 1'b1, 1, 10'h3FF, 2'b00, 64'hC3, -1, 1'b0);
    spi_frame("R11", 1'b0, 2, 10'h3FF, 2'b00, 64'h0, -1, 1'b0);
    // R8: suspension inside an instruction and inside read data
    spi_frame("R8", 1'b1, 1, 10'd4, 2'b00, 64'h5C, 7, 1'b0);
    spi_frame("R8", 1'b0, 2, 10'd9, 2'b00, 64'h0, 20, 1'b0);
    // R13: back-to-back frames under one enable window
    spi_frame("R13", 1'b1, 1, 10'd2, 2'b00, 64'h77, -1, 1'b1);
    spi_frame("R13", 1'b0, 1, 10'd2, 2'b00, 64'h0, -1, 1'b0);
    // R5 and R10: set bit order through one bit of the pair; next frame in same window still MSB first
    spi_frame("R5", 1'b1, 1, 10'd0, 2'b00, 64'h04, -1, 1'b1);
    spi_frame("R10", 1'b1, 1, 10'd5, 2'b00, 64'h5A, -1, 1'b0);
    chk("R5", regs[7:0], 8'h24);
    // R4: ascending addresses, least significant bit first
    spi_frame("R4", 1'b1, 3, 10'd10, 2'b00, 64'hC2_B1_A0, -1, 1'b0);
    spi_frame("R4", 1'b0, 3, 10'd10, 2'b00, 64'h0, -1, 1'b0);
    // R5: unused bits dropped, 3-wire selected
    spi_frame("R5", 1'b1, 1, 10'd0, 2'b00, 64'h5E, -1, 1'b0);
    chk("R5", regs[7:0], 8'h66);
    // R6: 3-wire reads and a write on the shared line
    spi_frame("R6", 1'b0, 2, 10'd11, 2'b00, 64'h0, -1, 1'b0);
    spi_frame("R6", 1'b1, 1, 10'd13, 2'b00, 64'hC3, -1, 1'b0);
    spi_frame("R6", 1'b0, 1, 10'd13, 2'b00, 64'h0, -1, 1'b0);
    // R9: soft reset, blocked write, release, accepted write
    spi_frame("R9", 1'b1, 1, 10'd0, 2'b00, 64'h81, -1, 1'b0);
    spi_frame("R9", 1'b1, 1, 10'd3, 2'b00, 64'hEE, -1, 1'b0);
    spi_frame("R9", 1'b0, 1, 10'd3, 2'b00, 64'h0, -1, 1'b0);
    spi_frame("R9", 1'b1, 1, 10'd0, 2'b00, 64'h00, -1, 1'b0);
    spi_frame("R9", 1'b1, 1, 10'd3, 2'b00, 64'hEE, -1, 1'b0);
    spi_frame("R7", 1'b0, 1, 10'd3, 2'b00, 64'h0, -1, 1'b0);

    wait_clk(20);
    chk("R2 all queued read bytes returned", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule